// File: doc/BRIEF.md
# Single-Bit-Difference Test Pair Qualifier

This block decides whether a candidate pair of input words, applied one after the other to a small pipeline, forms a usable delay-fault test for one chosen bit of one chosen stage. Each word passes through its own copy of the stage logic, giving an intermediate word, and then through its own copy of the downstream logic, giving a final word.

The pair qualifies only when both of these hold:

- the two intermediate words differ in the chosen bit and agree in every other bit;
- the two final words differ.

Because only the target bit differs at the stage, a fault that corrupts several bits of that stage at once can disturb nothing but that bit. The difference in the final words then guarantees that the disturbance is seen at the pipeline end.

The qualifying signal is the AND of the two checks. A pair that raises it is a test for the qualifying signal stuck at 0. The block holds no pair-search logic. A tool or a bench drives candidate pairs and reads the verdict. The verdict can be taken straight from the logic, or through one output register when the `OUT_REG` parameter is set.

Top module: `pair_qualifier`

## Requirements
- R1: The intermediate word is computed bit by bit. For bit j, the value is x[j mod IN_W] XOR (x[(j+1) mod IN_W] AND x[(j+2) mod IN_W]), where x is the input word.
- R2: The final word is computed bit by bit from the intermediate word m. For bit j, the value is m[j mod MID_W] XOR (m[(j+1) mod MID_W] OR m[(j+2) mod MID_W]).
- R3: The single-bit check is 1 only when the two intermediate words differ in bit `tgt_bit` and in no other bit.
- R4: When `word_a` equals `word_b`, the verdict is 0.
- R5: The verdict is 0 whenever the two final words are equal.
- R6: The verdict is the AND of the single-bit check (R3) and the final-word inequality check.
- R7: A value of `tgt_bit` of MID_W or more forces the verdict to 0. With the defaults, MID_W is 3, `tgt_bit` is 2 bits wide, and the value 3 is out of range.
- R8: With `OUT_REG`=1, `qual_valid` shows the verdict for the inputs present at the previous rising clock edge. With `OUT_REG`=0, `qual_valid` follows the inputs with no clock delay.
- R9: While `rst_n` is low, the registered `qual_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_a | input | IN_W | First candidate input word |
| word_b | input | IN_W | Second candidate input word |
| tgt_bit | input | $clog2(MID_W+1) | Index of the target intermediate bit |
| qual_valid | output | 1 | High when the pair qualifies for the target bit |

## Verification
The hardest case to reach from the ports is a qualifying pair. For it, the two intermediate words must differ in exactly the target bit, and that one-bit difference must also survive into the final words. Only a small fraction of pairs meet both conditions. The bench therefore sweeps every ordered pair of 3-bit words against every target index, including the out-of-range index. It confirms that qualifying pairs actually occur, so that the positive path is exercised as well as the rejections.

// File: rtl/pq_pkg.sv
package pq_pkg;

  function automatic int unsigned wrap_idx(input int unsigned i, input int unsigned w);
    return i % w;
  endfunction

  function automatic logic single_diff_at(input logic [31:0] diff, input int unsigned k,
                                          input int unsigned w);
    logic [31:0] expect_mask;
    if (k >= w) return 1'b0;
    expect_mask = 32'd1 << k;
    return diff == expect_mask;
  endfunction

endpackage

// File: rtl/pq_stage.sv
module pq_stage #(
  parameter int IN_W  = 3,
  parameter int MID_W = 3
) (
  input  logic [IN_W-1:0]  x,
  output logic [MID_W-1:0] m
);
  import pq_pkg::*;
  for (genvar j = 0; j < MID_W; j++) begin : g_bit
    localparam int unsigned I0 = j % IN_W;
    localparam int unsigned I1 = (j + 1) % IN_W;
    localparam int unsigned I2 = (j + 2) % IN_W;
    assign m[j] = x[I0] ^ (x[I1] & x[I2]);
  end
endmodule

// File: rtl/pq_down.sv
module pq_down #(
  parameter int MID_W = 3,
  parameter int OUT_W = 3
) (
  input  logic [MID_W-1:0] m,
  output logic [OUT_W-1:0] y
);
  for (genvar j = 0; j < OUT_W; j++) begin : g_bit
    localparam int unsigned I0 = j % MID_W;
    localparam int unsigned I1 = (j + 1) % MID_W;
    localparam int unsigned I2 = (j + 2) % MID_W;
    assign y[j] = m[I0] ^ (m[I1] | m[I2]);
  end
endmodule

// File: rtl/pq_single_bit.sv
module pq_single_bit #(
  parameter int MID_W = 3,
  parameter int KW    = 2
) (
  input  logic [MID_W-1:0] m_a,
  input  logic [MID_W-1:0] m_b,
  input  logic [KW-1:0]    k,
  output logic             hit,
  output logic             k_ok
);
  import pq_pkg::*;
  logic [31:0] diff;
  always_comb begin
    diff = '0;
    diff[MID_W-1:0] = m_a ^ m_b;
  end
  assign k_ok = (32'(k) < 32'(MID_W));
  assign hit  = single_diff_at(diff, 32'(k), MID_W);
endmodule

// File: rtl/pair_qualifier.sv
module pair_qualifier #(
  parameter int IN_W    = 3,
  parameter int MID_W   = 3,
  parameter int OUT_W   = 3,
  parameter bit OUT_REG = 1'b1,
  localparam int KW     = $clog2(MID_W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IN_W-1:0] word_a,
  input  logic [IN_W-1:0] word_b,
  input  logic [KW-1:0]   tgt_bit,
  output logic            qual_valid
);
  logic [MID_W-1:0] mid_a, mid_b;
  logic [OUT_W-1:0] fin_a, fin_b;
  logic             mid_single;
  logic             tgt_in_range;
  logic             out_differ;
  logic             qual_hit;

  pq_stage #(.IN_W(IN_W), .MID_W(MID_W)) u_stage_a (.x(word_a), .m(mid_a));
  pq_stage #(.IN_W(IN_W), .MID_W(MID_W)) u_stage_b (.x(word_b), .m(mid_b));
  pq_down  #(.MID_W(MID_W), .OUT_W(OUT_W)) u_down_a (.m(mid_a), .y(fin_a));
  pq_down  #(.MID_W(MID_W), .OUT_W(OUT_W)) u_down_b (.m(mid_b), .y(fin_b));

  pq_single_bit #(.MID_W(MID_W), .KW(KW)) u_single (
    .m_a(mid_a), .m_b(mid_b), .k(tgt_bit), .hit(mid_single), .k_ok(tgt_in_range)
  );

  assign out_differ = |(fin_a ^ fin_b);
  assign qual_hit   = mid_single & out_differ;

  if (OUT_REG) begin : g_reg
    logic valid_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= qual_hit;
    end
    assign qual_valid = valid_q;

    // R8: registered verdict follows the previous cycle's combinational verdict
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
      qual_hit |=> qual_valid);
    a_r8_latency_lo: assert property (@(posedge clk) disable iff (!rst_n)
      !qual_hit |=> !qual_valid);
  end else begin : g_comb
    assign qual_valid = qual_hit;
  end

  // R3: single-bit check implies exactly one differing intermediate bit
  a_r3_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    mid_single |-> ($countones(mid_a ^ mid_b) == 1));
  // R4: identical words never qualify
  a_r4_identical: assert property (@(posedge clk) disable iff (!rst_n)
    (word_a == word_b) |-> !qual_hit);
  // R5: equal final words never qualify
  a_r5_out_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_a == fin_b) |-> !qual_hit);
  // R7: out-of-range target index never qualifies
  a_r7_range: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_in_range |-> !mid_single);
endmodule

// File: tb/pair_qualifier_test.sv
module pair_qualifier_test;
  localparam int W = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] word_a = '0, word_b = '0;
  logic [1:0] tgt_bit = '0;
  logic qv_reg, qv_comb;
  int checks = 0, fails = 0, qualifying = 0;
  bit done = 0;

  typedef struct { logic exp; string tag; logic [W-1:0] a, b; logic [1:0] k; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  pair_qualifier #(.OUT_REG(1'b1)) uut (.clk(clk), .rst_n(rst_n), .word_a(word_a),
    .word_b(word_b), .tgt_bit(tgt_bit), .qual_valid(qv_reg));
  pair_qualifier #(.OUT_REG(1'b0)) uut_comb (.clk(clk), .rst_n(rst_n), .word_a(word_a),
    .word_b(word_b), .tgt_bit(tgt_bit), .qual_valid(qv_comb));

  function automatic logic [W-1:0] ror(input logic [W-1:0] v, input int s);
    return W'((v >> s) | (v << (W - s)));
  endfunction
  // R1 and R2 restated as rotations
  function automatic logic [W-1:0] stage_ref(input logic [W-1:0] x);
    return x ^ (ror(x, 1) & ror(x, 2));
  endfunction
  function automatic logic [W-1:0] down_ref(input logic [W-1:0] m);
    return m ^ (ror(m, 1) | ror(m, 2));
  endfunction
  function automatic logic verdict(input logic [W-1:0] a, b, input logic [1:0] k);
    logic [W-1:0] d;
    d = stage_ref(a) ^ stage_ref(b);
    if (k >= W) return 1'b0;
    return ($countones(d) == 1) && d[k] && (down_ref(stage_ref(a)) != down_ref(stage_ref(b)));
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, b, input logic [1:0] k);
    item_t it;
    @(negedge clk);
    word_a = a; word_b = b; tgt_bit = k;
    it.exp = verdict(a, b, k);
    if (k >= W) it.tag = "R7";
    else if (a == b) it.tag = "R4";
    else if (it.exp) it.tag = "R3/R6";
    else it.tag = "R5/R6";
    it.a = a; it.b = b; it.k = k;
    if (it.exp) qualifying++;
    sb.push_back(it);
  endtask

  // monitor: sample after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check($sformatf("R8 reg %s a=%b b=%b k=%0d", it.tag, it.a, it.b, it.k), qv_reg, it.exp);
        check($sformatf("R8 comb %s a=%b b=%b k=%0d", it.tag, it.a, it.b, it.k), qv_comb, it.exp);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    word_a = 3'b000; word_b = 3'b001; tgt_bit = 2'd0;
    repeat (3) @(negedge clk);
    check("R9 reset qual_valid", qv_reg, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // directed: known qualifying pair 000/001 at bit 0 (R3, R6)
    drive(3'b000, 3'b001, 2'd0);
    // same pair, wrong bit (R3)
    drive(3'b000, 3'b001, 2'd1);
    // identical (R4), out of range (R7)
    drive(3'b101, 3'b101, 2'd2);
    drive(3'b000, 3'b001, 2'd3);
    // exhaustive sweep
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int k = 0; k < 4; k++)
          drive(W'(a), W'(b), 2'(k));
    repeat (3) @(negedge clk);
    check("R5 qualifying pairs seen", qualifying > 0, 1'b1);
    check("R8 scoreboard drained", sb.size() == 0, 1'b1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule